// File: doc/BRIEF.md
# Nine-Bit Serial Word Packer

This block sits in front of an 8-bit-only serial master that talks to a display controller using 9-bit words. Each such word is a data/command flag followed by an 8-bit value. The block collects these words into groups of eight. Each group is 72 bits, which the block sends out as exactly nine bytes, so the master never needs a 9-bit word mode.

Commands always travel alone. A command byte is placed in the last of the eight word slots and the seven slots before it are all-zero no-op words. The nine-byte block therefore consists of eight zero bytes followed by the command value.

Data bytes fill the slots in arrival order. A data transfer that ends partway through a group is completed with zero words after the data. An optional swap reverses each pair of incoming data bytes, so little-endian 16-bit pixels go out high byte first. The end-of-transfer marker rides on the ninth byte of the block that closes a transfer.

Top module: `nine_bit_packer`

## Requirements
- R1: Each data byte becomes a 9-bit word of the form {1, byte[7:0]}. Eight such words are concatenated, slot 0 first and each word MSB first, into 72 bits, which leave as nine bytes with the most significant byte first.
- R2: A byte accepted with `inDc` = 0 is a command. It produces its own nine-byte block: eight bytes of 0x00, then a ninth byte equal to the command value. `outLast` is 1 on that ninth byte.
- R3: When a data transfer ends (`inLast` = 1) with fewer than eight words in the current group, the remaining slots after the data are filled with all-zero words, and a full nine-byte block is still sent.
- R4: `outLast` is 1 only on the ninth byte of a block. That block is either a command block, or the block holding a data byte accepted with `inLast` = 1, or a partial data block closed by a following command. A full data block sent without an end of transfer has `outLast` = 0 on all nine bytes.
- R5: With `swapEn` = 1, each pair of data bytes (transfer positions 2i and 2i+1) is placed into the slots in reversed order. A final unpaired byte that carries `inLast` keeps its own position.
- R6: A command that arrives while a partial data group is pending is not accepted at first. The pending group is first padded with zero words and sent with `outLast` = 1 on its ninth byte. The command then follows as its own block.
- R7: While `outValid` = 1 and `outReady` = 0, `outData` and `outLast` stay unchanged. `inReady` is 0 whenever `outValid` = 1, so a stall never loses or reorders bits.
- R8: After reset, `outValid` = 0 and `inReady` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input byte valid |
| inReady | output | 1 | Block accepts the input byte |
| inData | input | 8 | Input byte value |
| inDc | input | 1 | 1 = data byte, 0 = command byte |
| inLast | input | 1 | Last data byte of a transfer |
| swapEn | input | 1 | Reverse each pair of data bytes |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | Serial master takes the byte |
| outData | output | 8 | Packed output byte |
| outLast | output | 1 | Ninth byte of the block that closes a transfer |

## Verification
Two functions can coincide: a command can show up while a partial data group is still waiting, so closing that group competes with loading the command. The bench provokes this by sending an unterminated data run of five bytes and then issuing a command immediately after it. It judges the result against a model-built expected stream, which must show the padded data block ending with the marker and then the separate command block. The same stream is also run under pseudo-random output stalls.

// File: rtl/nine_pack_pkg.sv
package nine_pack_pkg;

  typedef enum logic {
    ST_FILL,
    ST_EMIT
  } packState_t;

  typedef struct packed {
    logic writeWord;
    logic loadCmd;
    logic advance;
    logic clearBlock;
  } packStrobe_t;

endpackage

// File: rtl/nine_pack_dp.sv
module nine_pack_dp
  import nine_pack_pkg::*;
#(
  parameter int WORD_BITS = 8,
  parameter int GROUP     = 8,
  localparam int SLOT_BITS  = WORD_BITS + 1,
  localparam int BLOCK_BITS = GROUP * SLOT_BITS,
  localparam int OUT_BYTES  = BLOCK_BITS / 8,
  localparam int CNT_W      = $clog2(GROUP),
  localparam int IDX_W      = $clog2(OUT_BYTES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  packStrobe_t          strobe,
  input  logic [WORD_BITS-1:0] inData,
  input  logic                 inLast,
  input  logic                 swapEn,
  output logic [CNT_W-1:0]     wordCount,
  output logic [IDX_W-1:0]     byteIdx,
  output logic [7:0]           outData
);

  logic [SLOT_BITS-1:0]  slotReg [GROUP];
  logic [BLOCK_BITS-1:0] blockFlat;
  logic [CNT_W-1:0]      slotSel;
  logic                  pairedSwap;

  // An unpaired final byte keeps its own slot; all others swap within the pair.
  always_comb begin
    pairedSwap = swapEn && !(inLast && !wordCount[0]);
    slotSel    = pairedSwap ? (wordCount ^ CNT_W'(1)) : wordCount;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < GROUP; k++) slotReg[k] <= '0;
    end else begin
      for (int k = 0; k < GROUP; k++) begin
        if (strobe.clearBlock)
          slotReg[k] <= '0;
        else if (strobe.writeWord && slotSel == CNT_W'(k))
          slotReg[k] <= {1'b1, inData};
        else if (strobe.loadCmd && k == GROUP - 1)
          slotReg[k] <= {1'b0, inData};
      end
    end
  end

  generate
    for (genvar g = 0; g < GROUP; g++) begin : gFlat
      assign blockFlat[BLOCK_BITS-1-g*SLOT_BITS -: SLOT_BITS] = slotReg[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordCount <= '0;
      byteIdx   <= '0;
    end else begin
      if (strobe.clearBlock)     wordCount <= '0;
      else if (strobe.writeWord) wordCount <= wordCount + CNT_W'(1);
      if (strobe.clearBlock)     byteIdx <= '0;
      else if (strobe.advance)   byteIdx <= byteIdx + IDX_W'(1);
    end
  end

  always_comb begin
    int base;
    base    = BLOCK_BITS - 1 - 8 * int'(byteIdx);
    outData = blockFlat[base -: 8];
  end

  // R1: a data word written at slot 0 makes the first block byte start with the flag
  p_flag_first_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.writeWord && slotSel == '0) |=> blockFlat[BLOCK_BITS-1]);

endmodule

// File: rtl/nine_pack_ctrl.sv
module nine_pack_ctrl
  import nine_pack_pkg::*;
#(
  parameter int GROUP     = 8,
  parameter int OUT_BYTES = 9,
  localparam int CNT_W    = $clog2(GROUP),
  localparam int IDX_W    = $clog2(OUT_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inDc,
  input  logic             inLast,
  input  logic             outReady,
  input  logic [CNT_W-1:0] wordCount,
  input  logic [IDX_W-1:0] byteIdx,
  output packStrobe_t      strobe,
  output logic             inReady,
  output logic             outValid,
  output logic             outLast
);

  packState_t state;
  logic       endFlag;
  logic       flushPending;
  logic       takeIn;
  logic       groupFull;
  logic       lastByte;

  always_comb begin
    flushPending      = (state == ST_FILL) && inValid && !inDc && (wordCount != '0);
    inReady           = (state == ST_FILL) && !flushPending;
    takeIn            = inValid && inReady;
    outValid          = (state == ST_EMIT);
    lastByte          = (byteIdx == IDX_W'(OUT_BYTES - 1));
    outLast           = outValid && lastByte && endFlag;
    groupFull         = (wordCount == CNT_W'(GROUP - 1));
    strobe.writeWord  = takeIn && inDc;
    strobe.loadCmd    = takeIn && !inDc;
    strobe.advance    = outValid && outReady;
    strobe.clearBlock = outValid && outReady && lastByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_FILL;
      endFlag <= 1'b0;
    end else begin
      case (state)
        ST_FILL: begin
          if (strobe.loadCmd || flushPending) begin
            state   <= ST_EMIT;
            endFlag <= 1'b1;
          end else if (strobe.writeWord && (inLast || groupFull)) begin
            state   <= ST_EMIT;
            endFlag <= inLast;
          end
        end
        default: if (strobe.clearBlock) state <= ST_FILL;
      endcase
    end
  end

  // R7: nothing is taken in while a block is being sent
  p_no_accept_emit_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  // R2: a command block opens with a zero byte
  p_cmd_lead_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !inDc) |=> (outValid && byteIdx == '0));

endmodule

// File: rtl/nine_bit_packer.sv
module nine_bit_packer
  import nine_pack_pkg::*;
#(
  parameter int WORD_BITS = 8,
  parameter int GROUP     = 8,
  localparam int SLOT_BITS  = WORD_BITS + 1,
  localparam int BLOCK_BITS = GROUP * SLOT_BITS,
  localparam int OUT_BYTES  = BLOCK_BITS / 8,
  localparam int CNT_W      = $clog2(GROUP),
  localparam int IDX_W      = $clog2(OUT_BYTES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  output logic                 inReady,
  input  logic [WORD_BITS-1:0] inData,
  input  logic                 inDc,
  input  logic                 inLast,
  input  logic                 swapEn,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [7:0]           outData,
  output logic                 outLast
);

  packStrobe_t      strobe;
  logic [CNT_W-1:0] wordCount;
  logic [IDX_W-1:0] byteIdx;

  nine_pack_ctrl #(.GROUP(GROUP), .OUT_BYTES(OUT_BYTES)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDc(inDc), .inLast(inLast),
    .outReady(outReady), .wordCount(wordCount), .byteIdx(byteIdx),
    .strobe(strobe), .inReady(inReady), .outValid(outValid), .outLast(outLast)
  );

  nine_pack_dp #(.WORD_BITS(WORD_BITS), .GROUP(GROUP)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData), .inLast(inLast),
    .swapEn(swapEn), .wordCount(wordCount), .byteIdx(byteIdx), .outData(outData)
  );

  // Independent handshake counter for the marker position check.
  logic [IDX_W-1:0] chkCnt;
  always_ff @(posedge clk) begin
    if (!rstN) chkCnt <= '0;
    else if (outValid && outReady)
      chkCnt <= (chkCnt == IDX_W'(OUT_BYTES - 1)) ? '0 : chkCnt + IDX_W'(1);
  end

  // R4: the end marker only ever sits on the ninth byte of a block
  p_last_ninth_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLast) |-> (chkCnt == IDX_W'(OUT_BYTES - 1)));

  // R7: a stalled byte holds its value and marker
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

endmodule

// File: tb/tb_nine_bit_packer.sv
`timescale 1ns/1ps
module tb_nine_bit_packer;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [7:0] inData = '0;
  logic inDc = 1'b0;
  logic inLast = 1'b0;
  logic swapEn = 1'b0;
  logic outValid;
  logic outReady = 1'b1;
  logic [7:0] outData;
  logic outLast;

  always #10 clk = ~clk;

  nine_bit_packer dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inDc(inDc), .inLast(inLast), .swapEn(swapEn),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outLast(outLast)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] expData[$];
  logic       expLast[$];
  string      expTag[$];
  bit         randReady = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] dbuf [64];
  logic [7:0] ord  [64];

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic pushBlock(input logic [8:0] w [8], input bit lastF, input string tag);
    logic [71:0] v;
    for (int k = 0; k < 8; k++) v[71-9*k -: 9] = w[k];
    for (int j = 0; j < 9; j++) begin
      expData.push_back(v[71-8*j -: 8]);
      expLast.push_back(lastF && j == 8);
      expTag.push_back(tag);
    end
  endtask

  task automatic sendByte(input logic [7:0] d, input bit dc, input bit last);
    inValid = 1'b1; inData = d; inDc = dc; inLast = last;
    #1;
    while (!inReady) begin @(negedge clk); #1; end
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic runCmd(input logic [7:0] c, input string tag);
    logic [8:0] w [8];
    for (int k = 0; k < 7; k++) w[k] = 9'h000;
    w[7] = {1'b0, c};
    pushBlock(w, 1'b1, tag);
    swapEn = 1'b0;
    sendByte(c, 1'b0, 1'b0);
  endtask

  // A data run; when lastEn is 0 a partial tail is expected to be closed by a later command.
  task automatic runData(input int n, input int seed, input bit sw, input bit lastEn, input string tag);
    logic [8:0] w [8];
    int pos;
    for (int i = 0; i < n; i++) dbuf[i] = 8'(seed + i * 37);
    for (int i = 0; i < n; i++) begin
      if (sw && (i % 2 == 0) && (i + 1 < n)) ord[i] = dbuf[i+1];
      else if (sw && (i % 2 == 1)) ord[i] = dbuf[i-1];
      else ord[i] = dbuf[i];
    end
    pos = 0;
    while (pos < n) begin
      for (int k = 0; k < 8; k++) w[k] = (pos + k < n) ? {1'b1, ord[pos+k]} : 9'h000;
      pushBlock(w, (pos + 8 >= n) && (lastEn || (n - pos) < 8), tag);
      pos += 8;
    end
    swapEn = sw;
    for (int i = 0; i < n; i++) sendByte(dbuf[i], 1'b1, lastEn && (i == n - 1));
  endtask

  // Monitor: scoreboard compare plus stall stability check.
  logic [7:0] heldData;
  logic       heldLast;
  bit         wasStalled = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (randReady) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        outReady = lfsr[0] | lfsr[3];
      end else outReady = 1'b1;
      #1;
      if (rstN && wasStalled) begin
        checks++;
        if (!outValid || outData != heldData || outLast != heldLast) begin
          errors++;
          $display("FAIL R7 stall hold: actual v=%0b d=%02h l=%0b expected v=1 d=%02h l=%0b",
                   outValid, outData, outLast, heldData, heldLast);
        end
      end
      wasStalled = 1'b0;
      if (rstN && outValid) begin
        if (!outReady) begin
          wasStalled = 1'b1; heldData = outData; heldLast = outLast;
        end else begin
          checks++;
          if (expData.size() == 0) begin
            errors++;
            $display("FAIL R4 unexpected byte: actual %02h expected none", outData);
          end else begin
            logic [7:0] ed; logic el; string et;
            ed = expData.pop_front(); el = expLast.pop_front(); et = expTag.pop_front();
            if (outData != ed || outLast != el) begin
              errors++;
              $display("FAIL %s: actual d=%02h l=%0b expected d=%02h l=%0b",
                       et, outData, outLast, ed, el);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R7: actual hung expected drained");
    report();
    $finish;
  end

  task automatic drain();
    int t;
    t = 0;
    while ((expData.size() != 0 || outValid) && t < 2000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    checks++;
    if (expData.size() != 0) begin
      errors++;
      $display("FAIL R4 missing bytes: actual %0d left expected 0", expData.size());
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    checks++;  // R8 reset state
    if (outValid !== 1'b0 || inReady !== 1'b1) begin
      errors++;
      $display("FAIL R8 reset: actual v=%0b r=%0b expected v=0 r=1", outValid, inReady);
    end
    @(negedge clk);

    runCmd(8'h2C, "R2 cmd 2C");
    runCmd(8'hA5, "R2 cmd A5");
    runData(8, 8'h11, 1'b0, 1'b1, "R1 full block");
    runData(16, 8'h80, 1'b0, 1'b1, "R1 two blocks");
    runData(3, 8'h40, 1'b0, 1'b1, "R3 pad three");
    runData(1, 8'hFF, 1'b0, 1'b1, "R3 pad one");
    runData(10, 8'h05, 1'b0, 1'b1, "R4 ten bytes");
    runData(8, 8'h21, 1'b1, 1'b1, "R5 swap even");
    runData(5, 8'h63, 1'b1, 1'b1, "R5 swap odd tail");
    runData(5, 8'h7A, 1'b0, 1'b0, "R6 flush before cmd");
    runCmd(8'h29, "R6 cmd after flush");
    runData(8, 8'h33, 1'b0, 1'b0, "R4 full no last");
    runCmd(8'h11, "R4 cmd after full");
    drain();

    randReady = 1'b1;
    runData(13, 8'h52, 1'b0, 1'b1, "R7 stalled data");
    runCmd(8'h3A, "R7 stalled cmd");
    runData(6, 8'h9C, 1'b1, 1'b1, "R7 stalled swap");
    runData(4, 8'h17, 1'b0, 1'b0, "R7 stalled flush");
    runCmd(8'h2A, "R7 stalled cmd2");
    drain();

    report();
    $finish;
  end

endmodule